// File: doc/BRIEF.md
# Accumulator Binary/Decimal Adder-Subtractor

This unit performs the accumulator's add-with-carry and subtract-with-borrow. One selector picks either plain binary arithmetic or packed BCD arithmetic. A second selector picks the operand width: a narrow byte or a wide 16-bit word. When the unit sees a start strobe it computes the result from the accumulator, the operand and the incoming carry. On the next clock edge it registers the new accumulator value together with the negative, zero, overflow and carry flags.

In narrow mode only the low byte of the accumulator takes part in the operation, and the high byte passes through unchanged. In decimal mode each 4-bit digit is corrected in turn, starting with the least significant digit. The carry or borrow ripples from one digit to the next. The flags always describe the active width only.

Top module: `acc_arith_unit`

## Requirements
- R1: After reset, resultAcc, flagN, flagZ, flagV, flagC and resultValid are all 0.
- R2: With binary mode, narrow width and add selected, {flagC, resultAcc[7:0]} equals accIn[7:0] + operand[7:0] + carryIn as a 9-bit sum.
- R3: A binary subtract is computed as accIn + ~operand + carryIn over the active width. carryIn = 1 means no borrow, and flagC = 1 means no borrow occurred.
- R4: In wide mode (wideMode = 1) all 16 bits take part. The carry comes from bit 16, and flagN and flagV come from bit 15.
- R5: In narrow mode (wideMode = 0), resultAcc[15:8] equals accIn[15:8] as it was presented with the strobe.
- R6: A decimal add (decimalMode = 1, subtract = 0) adds valid BCD values digit by digit. Any digit sum of ten or more is corrected and carries into the next digit. flagC is set when the sum exceeds 99 (narrow) or 9999 (wide).
- R7: A decimal subtract uses a borrow-in of ~carryIn and corrects every digit that underflows. flagC is the inverse of the borrow out of the top digit, so a negative difference wraps modulo 100 or 10000 and clears flagC.
- R8: flagV is bit 7 (narrow) or bit 15 (wide) of (R ^ accIn) & (R ^ E). Here R is the active-width result and E is operand for an add or ~operand for a subtract.
- R9: flagN is the top bit of the active width. flagZ is 1 exactly when the active-width result is zero, so the high byte is ignored in narrow mode.
- R10: Result and flags change only on the clock edge that samples startValid = 1. resultValid is 1 for exactly the cycle after each such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe; operands are sampled on this edge |
| accIn | input | 16 | Current accumulator value |
| operand | input | 16 | Second operand |
| carryIn | input | 1 | Carry in (for a subtract, 1 means no borrow) |
| decimalMode | input | 1 | 1 = packed BCD arithmetic |
| wideMode | input | 1 | 1 = 16-bit, 0 = 8-bit |
| subtract | input | 1 | 1 = subtract with borrow |
| resultAcc | output | 16 | Registered accumulator result |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag |
| resultValid | output | 1 | One-cycle pulse when new results are available |

## Verification
The hardest case to reach is a decimal carry or borrow that ripples through every digit of the active width. That happens only when each digit sits exactly at its limit, for example 9999 + 1 or 1000 - 1, and it also exercises the choice of which digit's carry becomes flagC in each width. The bench drives these edge values directly in both widths. It compares them against a model that works on whole decimal numbers rather than on digits. It also checks that narrow operations leave a distinctive high byte untouched and ignore it when computing the zero flag.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic load;
    logic decimal;
    logic wide;
    logic sub;
  } arithStrobe_t;
endpackage

// File: rtl/acc_arith_digit.sv
module acc_arith_digit
  import acc_arith_pkg::*;
(
  input  logic [DIGIT_W-1:0] aDigit,
  input  logic [DIGIT_W-1:0] bDigit,
  input  logic               cin,
  input  logic               sub,
  output logic [DIGIT_W-1:0] digitOut,
  output logic               cout
);
  logic [DIGIT_W:0] addRaw;
  logic [DIGIT_W:0] subRaw;
  logic             addFix;
  logic             subNeg;

  always_comb begin
    addRaw = {1'b0, aDigit} + {1'b0, bDigit} + {{DIGIT_W{1'b0}}, cin};
    subRaw = {1'b0, aDigit} - {1'b0, bDigit} - {{DIGIT_W{1'b0}}, ~cin};
    addFix = (addRaw >= (DIGIT_W+1)'(10));
    subNeg = subRaw[DIGIT_W];
    if (sub) begin
      digitOut = subNeg ? (subRaw[DIGIT_W-1:0] - DIGIT_W'(6)) : subRaw[DIGIT_W-1:0];
      cout     = ~subNeg;
    end else begin
      digitOut = addFix ? (addRaw[DIGIT_W-1:0] + DIGIT_W'(6)) : addRaw[DIGIT_W-1:0];
      cout     = addFix;
    end
  end
endmodule

// File: rtl/acc_arith_ctrl.sv
module acc_arith_ctrl
  import acc_arith_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic         decimalMode,
  input  logic         wideMode,
  input  logic         subtract,
  output arithStrobe_t strobe,
  output logic         resultValid
);
  always_comb begin
    strobe.load    = startValid;
    strobe.decimal = decimalMode;
    strobe.wide    = wideMode;
    strobe.sub     = subtract;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= startValid;
  end
endmodule

// File: rtl/acc_arith_datapath.sv
module acc_arith_datapath
  import acc_arith_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  arithStrobe_t      strobe,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resultAcc,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);
  localparam int NARROW_W      = DATA_W / 2;
  localparam int NUM_DIGITS    = DATA_W / DIGIT_W;
  localparam int NARROW_DIGITS = NARROW_W / DIGIT_W;

  logic [DATA_W-1:0]   bEff;
  logic [DATA_W:0]     wideSum;
  logic [NARROW_W:0]   narrowSum;
  logic [DATA_W-1:0]   decRes;
  logic [NUM_DIGITS:0] digitCarry;
  logic [DATA_W-1:0]   rawRes;
  logic [DATA_W-1:0]   merged;
  logic [DATA_W-1:0]   ovfVec;
  logic                nextN, nextZ, nextV, nextC, binCarry, decCarry;

  assign bEff      = strobe.sub ? ~operand : operand;
  assign wideSum   = {1'b0, accIn} + {1'b0, bEff} + {{DATA_W{1'b0}}, carryIn};
  assign narrowSum = {1'b0, accIn[NARROW_W-1:0]} + {1'b0, bEff[NARROW_W-1:0]}
                   + {{NARROW_W{1'b0}}, carryIn};

  assign digitCarry[0] = carryIn;
  generate
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
      acc_arith_digit u_digit (
        .aDigit  (accIn[d*DIGIT_W +: DIGIT_W]),
        .bDigit  (operand[d*DIGIT_W +: DIGIT_W]),
        .cin     (digitCarry[d]),
        .sub     (strobe.sub),
        .digitOut(decRes[d*DIGIT_W +: DIGIT_W]),
        .cout    (digitCarry[d+1])
      );
    end
  endgenerate

  always_comb begin
    binCarry = strobe.wide ? wideSum[DATA_W] : narrowSum[NARROW_W];
    decCarry = strobe.wide ? digitCarry[NUM_DIGITS] : digitCarry[NARROW_DIGITS];
    if (strobe.decimal)  rawRes = decRes;
    else if (strobe.wide) rawRes = wideSum[DATA_W-1:0];
    else                  rawRes = {{(DATA_W-NARROW_W){1'b0}}, narrowSum[NARROW_W-1:0]};
    merged = strobe.wide ? rawRes : {accIn[DATA_W-1:NARROW_W], rawRes[NARROW_W-1:0]};
    ovfVec = (rawRes ^ accIn) & (rawRes ^ bEff);
    nextN  = strobe.wide ? rawRes[DATA_W-1] : rawRes[NARROW_W-1];
    nextZ  = strobe.wide ? (rawRes == '0) : (rawRes[NARROW_W-1:0] == '0);
    nextV  = strobe.wide ? ovfVec[DATA_W-1] : ovfVec[NARROW_W-1];
    nextC  = strobe.decimal ? decCarry : binCarry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultAcc <= '0;
      flagN     <= 1'b0;
      flagZ     <= 1'b0;
      flagV     <= 1'b0;
      flagC     <= 1'b0;
    end else if (strobe.load) begin
      resultAcc <= merged;
      flagN     <= nextN;
      flagZ     <= nextZ;
      flagV     <= nextV;
      flagC     <= nextC;
    end
  end
endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
  import acc_arith_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic              decimalMode,
  input  logic              wideMode,
  input  logic              subtract,
  output logic [DATA_W-1:0] resultAcc,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC,
  output logic              resultValid
);
  arithStrobe_t strobe;

  acc_arith_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .decimalMode(decimalMode),
    .wideMode   (wideMode),
    .subtract   (subtract),
    .strobe     (strobe),
    .resultValid(resultValid)
  );

  acc_arith_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .accIn    (accIn),
    .operand  (operand),
    .carryIn  (carryIn),
    .resultAcc(resultAcc),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagV    (flagV),
    .flagC    (flagC)
  );
endmodule

// File: rtl/acc_arith_checker.sv
module acc_arith_checker (
  input logic        clk,
  input logic        rstN,
  input logic        startValid,
  input logic [15:0] accIn,
  input logic [15:0] operand,
  input logic        carryIn,
  input logic        decimalMode,
  input logic        wideMode,
  input logic        subtract,
  input logic [15:0] resultAcc,
  input logic        flagN,
  input logic        flagZ,
  input logic        flagV,
  input logic        flagC,
  input logic        resultValid
);
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> resultValid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> (!resultValid && $stable(resultAcc) && $stable(flagC)
                     && $stable(flagV) && $stable(flagN) && $stable(flagZ)));

  assert_keep_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !wideMode) |=> resultAcc[15:8] == $past(accIn[15:8]));

  assert_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> flagZ == ($past(wideMode) ? (resultAcc == 16'h0)
                                              : (resultAcc[7:0] == 8'h0)));

  assert_neg_R9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> flagN == ($past(wideMode) ? resultAcc[15] : resultAcc[7]));

  assert_bin_add_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !decimalMode && !subtract && !wideMode) |=>
      {flagC, resultAcc[7:0]} == ({1'b0, $past(accIn[7:0])} + {1'b0, $past(operand[7:0])}
                                  + {8'h00, $past(carryIn)}));
endmodule

bind acc_arith_unit acc_arith_checker u_acc_arith_checker (
  .clk(clk), .rstN(rstN), .startValid(startValid), .accIn(accIn),
  .operand(operand), .carryIn(carryIn), .decimalMode(decimalMode),
  .wideMode(wideMode), .subtract(subtract), .resultAcc(resultAcc),
  .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
  .resultValid(resultValid)
);

// File: tb/acc_arith_unit_bench.sv
module acc_arith_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [15:0] accIn = '0;
  logic [15:0] operand = '0;
  logic        carryIn = 1'b0;
  logic        decimalMode = 1'b0;
  logic        wideMode = 1'b0;
  logic        subtract = 1'b0;
  logic [15:0] resultAcc;
  logic        flagN, flagZ, flagV, flagC, resultValid;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  acc_arith_unit u_acc_arith_unit (
    .clk(clk), .rstN(rstN), .startValid(startValid), .accIn(accIn),
    .operand(operand), .carryIn(carryIn), .decimalMode(decimalMode),
    .wideMode(wideMode), .subtract(subtract), .resultAcc(resultAcc),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .resultValid(resultValid)
  );

  task automatic check(input string req, input string what, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  function automatic int bcdToInt(input int v, input int digits);
    int n = 0;
    int scale = 1;
    for (int i = 0; i < digits; i++) begin
      n += ((v >> (4*i)) & 15) * scale;
      scale *= 10;
    end
    return n;
  endfunction

  function automatic int intToBcd(input int n, input int digits);
    int v = 0;
    for (int i = 0; i < digits; i++) begin
      v |= (n % 10) << (4*i);
      n /= 10;
    end
    return v;
  endfunction

  task automatic runOp(input string req, input int a, input int b, input int c,
                       input int dec, input int wide, input int sub);
    int mask, w, digits, modv, aM, bM, eff, r, carry, val, expAcc, ovf;
    w = wide ? 16 : 8;
    mask = (1 << w) - 1;
    digits = w / 4;
    aM = a & mask;
    bM = b & mask;
    eff = sub ? (~b & mask) : bM;
    if (dec != 0) begin
      modv = wide ? 10000 : 100;
      if (sub != 0) val = bcdToInt(aM, digits) - bcdToInt(bM, digits) - (1 - c);
      else          val = bcdToInt(aM, digits) + bcdToInt(bM, digits) + c;
      carry = (sub != 0) ? ((val >= 0) ? 1 : 0) : ((val >= modv) ? 1 : 0);
      val = (val + modv) % modv;
      r = intToBcd(val, digits);
    end else begin
      val = aM + eff + c;
      r = val & mask;
      carry = (val >> w) & 1;
    end
    ovf = (((r ^ aM) & (r ^ eff)) >> (w-1)) & 1;
    expAcc = wide ? r : ((a & 16'hFF00) | r);
    @(negedge clk);
    accIn = a[15:0]; operand = b[15:0]; carryIn = c[0];
    decimalMode = dec[0]; wideMode = wide[0]; subtract = sub[0];
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    check(req, "result", int'(resultAcc), expAcc);
    check(req, "C", int'(flagC), carry);
    check(req, "V", int'(flagV), ovf);
    check(req, "N", int'(flagN), (r >> (w-1)) & 1);
    check(req, "Z", int'(flagZ), (r == 0) ? 1 : 0);
    check(req, "valid", int'(resultValid), 1);
  endtask

  task automatic test_reset();
    check("R1", "result", int'(resultAcc), 0);
    check("R1", "flags", int'({flagN, flagZ, flagV, flagC}), 0);
    check("R1", "valid", int'(resultValid), 0);
  endtask

  task automatic test_bin_add8();
    runOp("R2", 16'h0012, 16'h0034, 0, 0, 0, 0);
    runOp("R2", 16'h00FF, 16'h0001, 0, 0, 0, 0);
    runOp("R2", 16'h0080, 16'h0080, 1, 0, 0, 0);
  endtask

  task automatic test_bin_sub();
    runOp("R3", 16'h0050, 16'h0020, 1, 0, 0, 1);
    runOp("R3", 16'h0020, 16'h0050, 1, 0, 0, 1);
    runOp("R3", 16'h0020, 16'h0020, 0, 0, 0, 1);
    runOp("R3", 16'h1000, 16'h0001, 1, 0, 1, 1);
  endtask

  task automatic test_bin16();
    runOp("R4", 16'hFFFF, 16'h0001, 0, 0, 1, 0);
    runOp("R4", 16'h1234, 16'h4321, 1, 0, 1, 0);
    runOp("R4", 16'h00FF, 16'h0001, 0, 0, 1, 0);
  endtask

  task automatic test_keep_high();
    runOp("R5", 16'hBEEF, 16'h5511, 0, 0, 0, 0);
    runOp("R5", 16'hC399, 16'h0001, 0, 1, 0, 0);
  endtask

  task automatic test_dec_add();
    runOp("R6", 16'h0045, 16'h0038, 0, 1, 0, 0);
    runOp("R6", 16'h0099, 16'h0001, 0, 1, 0, 0);
    runOp("R6", 16'h9999, 16'h0001, 0, 1, 1, 0);
    runOp("R6", 16'h1234, 16'h5678, 1, 1, 1, 0);
    runOp("R6", 16'h0050, 16'h0049, 1, 1, 0, 0);
  endtask

  task automatic test_dec_sub();
    runOp("R7", 16'h0000, 16'h0001, 1, 1, 0, 1);
    runOp("R7", 16'h0050, 16'h0025, 0, 1, 0, 1);
    runOp("R7", 16'h1000, 16'h0001, 1, 1, 1, 1);
    runOp("R7", 16'h0000, 16'h0000, 0, 1, 1, 1);
  endtask

  task automatic test_overflow();
    runOp("R8", 16'h007F, 16'h0001, 0, 0, 0, 0);
    runOp("R8", 16'h0080, 16'h0001, 1, 0, 0, 1);
    runOp("R8", 16'h7FFF, 16'h0001, 0, 0, 1, 0);
    runOp("R8", 16'h0040, 16'h0020, 0, 0, 0, 0);
  endtask

  task automatic test_flags_nz();
    runOp("R9", 16'h0100, 16'h0000, 0, 0, 1, 0);
    runOp("R9", 16'h1200, 16'h0000, 0, 0, 0, 0);
    runOp("R9", 16'h0080, 16'h0000, 0, 0, 1, 0);
    runOp("R9", 16'h8000, 16'h0000, 0, 0, 0, 0);
  endtask

  task automatic test_hold();
    logic [15:0] keepAcc;
    logic [3:0]  keepFlags;
    runOp("R10", 16'h0033, 16'h0044, 0, 0, 0, 0);
    keepAcc = resultAcc;
    keepFlags = {flagN, flagZ, flagV, flagC};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      accIn = 16'hFFFF; operand = 16'hFFFF; carryIn = 1'b1; wideMode = 1'b1;
    end
    check("R10", "held result", int'(resultAcc), int'(keepAcc));
    check("R10", "held flags", int'({flagN, flagZ, flagV, flagC}), int'(keepFlags));
    check("R10", "valid low", int'(resultValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_bin_add8();
    test_bin_sub();
    test_bin16();
    test_keep_high();
    test_dec_add();
    test_dec_sub();
    test_overflow();
    test_flags_nz();
    test_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule